// File: doc/BRIEF.md
# Sticky Event Status Bank with Level-Held Clear

This block turns a vector of asynchronous event lines, such as per-line loss-of-signal flags or component fault indications, into sticky status bits that a host reads over a simple synchronous register bus. Each event line is brought into the bus clock domain through a two-stage synchronizer. A synchronized line that is active sets its status bit, and the bit stays set after the line goes quiet.

A hold-clear register gives software a per-bit clear that lasts as long as the bit is held. While a hold bit is 1, the matching status bit is forced to 0 and the input is not captured. Writing the hold bit back to 0 resumes monitoring. An enable register picks which status bits can drive the single registered interrupt line. Every bus write and read is acknowledged exactly one clock after its strobe. The event width is a parameter; typical instances use 8 or 32 events.

Top module: `evt_sticky_bank`

## Requirements
- R1: After reset, the status, hold-clear and enable registers read as 0, and `irq_o`, `wack_o` and `rack_o` are low.
- R2: An event level present on `evt_i` at rising edge k sets its status bit at edge k+2. The bit then stays 1 after the input returns to 0, including after a pulse that lasts one clock.
- R3: Writing 1 to a bit of the hold-clear register (offset 0x4) clears the matching status bit at the edge after the write edge.
- R4: While a hold-clear bit is 1, the matching status bit stays 0 even if its synchronized input is active. When capture and hold meet in the same cycle, the hold wins.
- R5: After a 0 is written to a hold-clear bit, capture resumes. An input that is still active sets the status bit at the edge after the write edge.
- R6: The enable register is at offset 0x8, and 1 in a bit enables that bit. `irq_o` is registered: at each edge it takes the OR over all bits of status AND enable as they stood before that edge.
- R7: `wack_o` is 1 in exactly the cycle after each cycle in which `wr_i` is sampled high. `rack_o` behaves the same way for `rd_i`.
- R8: A read returns the contents at the sampling edge of status (offset 0x0), hold-clear (0x4) or enable (0x8), zero-extended to the data width, on `rdata_o` together with `rack_o`. A read of any other offset returns 0 and is still acknowledged. `rdata_o` is 0 in cycles without `rack_o`.
- R9: Writes to the status offset or to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | EVT_W | Asynchronous event levels, active high |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data; the low EVT_W bits are used |
| wr_i | input | 1 | Write strobe, one per cycle |
| rd_i | input | 1 | Read strobe, one per cycle |
| rdata_o | output | DATA_W | Read data, valid with rack_o |
| wack_o | output | 1 | Write acknowledge |
| rack_o | output | 1 | Read acknowledge |
| irq_o | output | 1 | Interrupt request, level |

## Verification
Acknowledges and read data are due one edge after the strobe. An event level is readable in status two edges after it is sampled. A status or enable change reaches `irq_o` one edge later. A hold write acts on status at the edge after the write edge. The bench drives inputs on falling edges and advances a behavioural reference model on rising edges. It compares every output on the next falling edge, so each result is checked in the exact cycle it is due. Directed reads issued back to back after hold writes pin down the one-cycle gap between release and recapture.

// File: rtl/evt_bank_pkg.sv
package evt_bank_pkg;
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_HOLD   = 4;
  localparam int unsigned OFS_ENABLE = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_HOLD,
    SEL_ENABLE
  } reg_sel_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/evt_capture.sv
module evt_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] hold_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] status_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // hold dominates a same-cycle capture
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        status_q[b] <= 1'b0;
      else if (hold_i[b]) status_q[b] <= 1'b0;
      else if (evt_i[b])  status_q[b] <= 1'b1;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/evt_host_regs.sv
module evt_host_regs
  import evt_bank_pkg::*;
#(
  parameter int EVT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [EVT_W-1:0]  status_i,
  output logic [EVT_W-1:0]  hold_o,
  output logic [EVT_W-1:0]  enable_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wack_o,
  output logic              rack_o
);
  reg_sel_e          sel;
  logic [EVT_W-1:0]  hold_q, enable_q, wval;
  logic [DATA_W-1:0] rmux, rdata_q;
  logic              wack_q, rack_q;

  always_comb begin
    if (addr_i == ADDR_W'(OFS_STATUS))      sel = SEL_STATUS;
    else if (addr_i == ADDR_W'(OFS_HOLD))   sel = SEL_HOLD;
    else if (addr_i == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
    else                                    sel = SEL_NONE;
  end

  assign wval = wdata_i[EVT_W-1:0];

  if (DATA_W > EVT_W) begin : g_spare
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[DATA_W-1:EVT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      enable_q <= '0;
    end else if (wr_i) begin
      if (sel == SEL_HOLD)   hold_q   <= wval;
      if (sel == SEL_ENABLE) enable_q <= wval;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: rmux = DATA_W'(status_i);
      SEL_HOLD:   rmux = DATA_W'(hold_q);
      SEL_ENABLE: rmux = DATA_W'(enable_q);
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wack_q  <= 1'b0;
      rack_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      wack_q  <= wr_i;
      rack_q  <= rd_i;
      rdata_q <= rd_i ? rmux : '0;
    end
  end

  assign hold_o   = hold_q;
  assign enable_o = enable_q;
  assign rdata_o  = rdata_q;
  assign wack_o   = wack_q;
  assign rack_o   = rack_q;
endmodule

// File: rtl/evt_irq.sv
module evt_irq #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] enable_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_i & enable_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank #(
  parameter int EVT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wack_o,
  output logic              rack_o,
  output logic              irq_o
);
  logic [EVT_W-1:0] sync_w, status_w, hold_w, enable_w;

  evt_sync #(.W(EVT_W), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (evt_i),
    .q_o   (sync_w)
  );

  evt_capture #(.W(EVT_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (sync_w),
    .hold_i  (hold_w),
    .status_o(status_w)
  );

  evt_host_regs #(.EVT_W(EVT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .status_i(status_w),
    .hold_o  (hold_w),
    .enable_o(enable_w),
    .rdata_o (rdata_o),
    .wack_o  (wack_o),
    .rack_o  (rack_o)
  );

  evt_irq #(.W(EVT_W)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status_w),
    .enable_i(enable_w),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/evt_sticky_bank_chk.sv
module evt_sticky_bank_chk #(
  parameter int EVT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              wack_o,
  input logic              rack_o,
  input logic              irq_o,
  input logic [EVT_W-1:0]  status_w,
  input logic [EVT_W-1:0]  hold_w,
  input logic [EVT_W-1:0]  enable_w
);
  logic unmapped;
  assign unmapped = (addr_i != ADDR_W'(0)) && (addr_i != ADDR_W'(4)) && (addr_i != ADDR_W'(8));

  p_wack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_i |=> wack_o);
  p_wack_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) !wr_i |=> !wack_o);
  p_rack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_i |=> rack_o);
  p_rack_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) !rd_i |=> !rack_o);

  p_hold_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_w & $past(hold_w)) == '0));

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_w) & ~status_w) & ~$past(hold_w)) == '0));

  p_irq_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_w & enable_w) == '0) |=> !irq_o);
  p_irq_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_w & enable_w) != '0) |=> irq_o);

  p_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && unmapped) |=> (rack_o && rdata_o == '0));
  p_idle_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
endmodule

bind evt_sticky_bank evt_sticky_bank_chk #(
  .EVT_W(EVT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/evt_sticky_bank_bench.sv
`timescale 1ns/1ps
module evt_sticky_bank_bench;
  localparam int EW = 8;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [EW-1:0] evt_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          wr_i = 1'b0;
  logic          rd_i = 1'b0;
  logic [DW-1:0] rdata_o;
  logic          wack_o, rack_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  evt_sticky_bank #(.EVT_W(EW), .DATA_W(DW), .ADDR_W(AW)) u_evt_sticky_bank (.*);

  // reference model
  logic [EW-1:0] m_status, m_hold, m_enable, cap;
  logic [EW-1:0] m_pipe[$];
  logic [DW-1:0] m_rdata;
  logic          m_wack, m_rack, m_irq;
  bit            m_live = 1'b0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_status = '0; m_hold = '0; m_enable = '0;
      m_rdata = '0; m_wack = 1'b0; m_rack = 1'b0; m_irq = 1'b0;
      m_pipe = {};
      m_pipe.push_back('0);
      m_pipe.push_back('0);
      m_live = 1'b0;
    end else begin
      logic [EW-1:0] nxt_status;
      logic [DW-1:0] nxt_rdata;
      cap = m_pipe.pop_front();
      m_pipe.push_back(evt_i);
      nxt_rdata = '0;
      if (rd_i) begin
        case (addr_i)
          4'h0:    nxt_rdata = DW'(m_status);
          4'h4:    nxt_rdata = DW'(m_hold);
          4'h8:    nxt_rdata = DW'(m_enable);
          default: nxt_rdata = '0;
        endcase
      end
      m_irq = |(m_status & m_enable);
      nxt_status = m_status;
      for (int b = 0; b < EW; b++) begin
        if (m_hold[b])     nxt_status[b] = 1'b0;
        else if (cap[b])   nxt_status[b] = 1'b1;
      end
      if (wr_i && addr_i == 4'h4) m_hold   = wdata_i[EW-1:0];
      if (wr_i && addr_i == 4'h8) m_enable = wdata_i[EW-1:0];
      m_status = nxt_status;
      m_rdata  = nxt_rdata;
      m_wack   = wr_i;
      m_rack   = rd_i;
      m_live   = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (m_live && rst_ni && !done) begin
      chk("R6 irq vs model", DW'(irq_o), DW'(m_irq));
      chk("R7 wack vs model", DW'(wack_o), DW'(m_wack));
      chk("R7 rack vs model", DW'(rack_o), DW'(m_rack));
      chk("R8 rdata vs model", rdata_o, m_rdata);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    chk("R7 write ack", DW'(wack_o), 1);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    chk("R7 read ack", DW'(rack_o), 1);
    d = rdata_o;
    rd_i = 1'b0;
  endtask

  task automatic read_expect(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    logic [DW-1:0] d;
    bus_read(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 irq after reset", DW'(irq_o), 0);
    chk("R1 wack after reset", DW'(wack_o), 0);
    chk("R1 rack after reset", DW'(rack_o), 0);
    read_expect(4'h0, 0, "R1 status after reset");
    read_expect(4'h4, 0, "R1 hold after reset");
    read_expect(4'h8, 0, "R1 enable after reset");

    // R2 level then pulse
    evt_i = 8'h05; idle(4); evt_i = '0; idle(4);
    read_expect(4'h0, 32'h05, "R2 sticky after level");
    evt_i = 8'h80; idle(1); evt_i = '0; idle(4);
    read_expect(4'h0, 32'h85, "R2 one-cycle pulse captured");

    // R6 enable and irq timing
    chk("R6 irq off while disabled", DW'(irq_o), 0);
    bus_write(4'h8, 32'h04);
    chk("R6 irq not yet", DW'(irq_o), 0);
    idle(1);
    chk("R6 irq one edge after enable", DW'(irq_o), 1);
    bus_write(4'h8, 32'h40);
    idle(1);
    chk("R6 irq off for idle bit", DW'(irq_o), 0);
    bus_write(4'h8, 32'h01);
    idle(1);
    chk("R6 irq on bit0", DW'(irq_o), 1);

    // R3 hold clears one edge later
    bus_write(4'h4, 32'h01);
    read_expect(4'h0, 32'h85, "R3 status before clear edge");
    read_expect(4'h0, 32'h84, "R3 status cleared");
    chk("R6 irq drops after clear", DW'(irq_o), 0);

    // R4 hold blocks capture
    evt_i = 8'h01; idle(5);
    read_expect(4'h0, 32'h84, "R4 held bit ignores event");
    read_expect(4'h4, 32'h01, "R8 hold readback");

    // R5 release with input still active
    bus_write(4'h4, 32'h00);
    read_expect(4'h0, 32'h84, "R5 not yet recaptured");
    read_expect(4'h0, 32'h85, "R5 recaptured one edge after release");
    evt_i = '0;

    // R9 ignored writes, R8 unmapped reads
    bus_write(4'h0, 32'hFF);
    read_expect(4'h0, 32'h85, "R9 status write ignored");
    bus_write(4'hC, 32'hFF);
    read_expect(4'h4, 32'h00, "R9 unmapped write leaves hold");
    read_expect(4'h8, 32'h01, "R9 unmapped write leaves enable");
    read_expect(4'hC, 32'h00, "R8 unmapped read zero");
    read_expect(4'h1, 32'h00, "R8 misaligned read zero");

    // R4 full hold against active inputs, then R5 release
    bus_write(4'h4, 32'hFF);
    evt_i = 8'hFF; idle(4);
    read_expect(4'h0, 32'h00, "R4 all bits held");
    chk("R6 irq low while held", DW'(irq_o), 0);
    bus_write(4'h4, 32'h00);
    read_expect(4'h0, 32'h00, "R5 still clear at release edge");
    read_expect(4'h0, 32'hFF, "R5 all recaptured");
    evt_i = '0;
    idle(2);
    chk("R6 irq after recapture", DW'(irq_o), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule